// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between the serial slave engine of a two-wire EEPROM model and its storage array. During a write transaction the slave engine first loads a page number and a starting byte offset, then presents each received data byte with a one-cycle strobe. The block holds those bytes in a page-sized buffer and keeps a valid bit for every offset it has received.

When the engine reports the bus Stop, the block decides whether to program. If at least one byte was received and the write-protect pin is low at that moment, it raises `busy`, waits a programmable number of clocks in place of the real cell programming time, and then walks the buffer from offset 0 upward. Each valid offset produces a single-cycle array write request. After the last offset `busy` drops and the buffer is empty again. While `busy` is high the slave engine's requests are ignored, which lets the engine answer acknowledge polling with a NACK.

Top module: `pagebuf_commit`

## Requirements
- R1: A pulse on `offLoad` latches `pageIn` and `offIn`, and it discards every byte buffered earlier. Only bytes received after the latest load are written.
- R2: Each `byteStb` stores `byteData` at the current offset, and the offset then advances by one modulo the page size (255 wraps to 0). Every array write uses address `{page, offset}`, with the page in the upper bits and the 8-bit offset in the low bits.
- R3: When more bytes arrive than the page holds, a later byte replaces the earlier one at the same wrapped offset. Each offset is written at most once per commit, and it carries the newest value.
- R4: A `stopStb` with at least one buffered byte and `wpPin` low raises `busy` in the following cycle. A `stopStb` with no buffered byte starts nothing.
- R5: A commit keeps `busy` high for exactly `CYCLE_CLKS + PAGE_BYTES` cycles. Array writes occur only after the first `CYCLE_CLKS` of those cycles, in strictly ascending offset order.
- R6: `wpPin` is sampled only at `stopStb`. If it is high then, no cycle starts, nothing is written and the buffered bytes are discarded. Its level while bytes arrive has no effect.
- R7: While `busy` is high, `offLoad`, `byteStb` and `stopStb` are ignored. They start no second cycle and leave the pending commit unchanged.
- R8: Only offsets actually received since the last load are written. A commit writes exactly as many array bytes as distinct offsets were received.
- R9: After reset, `busy` and `arrWrEn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pageIn | input | PAGE_IDX_W | Page number, latched on offLoad |
| offIn | input | OFF_W | Start offset within page, latched on offLoad |
| offLoad | input | 1 | Start of a write transaction |
| byteStb | input | 1 | One received data byte |
| byteData | input | 8 | Data for byteStb |
| stopStb | input | 1 | Bus Stop seen by the slave engine |
| wpPin | input | 1 | Write protect, high blocks commits |
| busy | output | 1 | Programming cycle in progress |
| arrWrEn | output | 1 | Array write request |
| arrWrAddr | output | PAGE_IDX_W+OFF_W | Array write address |
| arrWrData | output | 8 | Array write data |

## Verification
The assertions assume that the slave engine raises at most one of `offLoad`, `byteStb` and `stopStb` in any cycle, because a single decoded bus event is one of those three. The bench drives each event as a separate one-cycle pulse, so it keeps within that assumption even when it deliberately sends traffic during a busy cycle. The properties also assume that the page upper bits seen on the array port belong to the page latched before the Stop. The bench checks this by never reloading a page during a commit except in the test where reloads are expected to be ignored.

// File: rtl/pagebuf_pkg.sv
package pagebuf_pkg;

  typedef enum logic [1:0] {
    PB_IDLE = 2'd0,
    PB_WAIT = 2'd1,
    PB_SCAN = 2'd2
  } pbState_t;

  typedef struct packed {
    logic loadOffset;
    logic storeByte;
    logic clearMask;
    logic scanStart;
    logic scanStep;
  } pbStrobe_t;

endpackage

// File: rtl/pagebuf_ctrl.sv
module pagebuf_ctrl
  import pagebuf_pkg::*;
#(
  parameter int CYCLE_CLKS = 250000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      offLoad,
  input  logic      byteStb,
  input  logic      stopStb,
  input  logic      wpPin,
  input  logic      anyValid,
  input  logic      scanLast,
  output pbStrobe_t strobes,
  output logic      busy
);

  localparam int CNT_W = $clog2(CYCLE_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYCLE_CLKS - 1);

  pbState_t state, nextState;
  logic [CNT_W-1:0] waitCnt;

  always_comb begin
    strobes   = '0;
    nextState = state;
    unique case (state)
      PB_IDLE: begin
        if (offLoad) begin
          strobes.loadOffset = 1'b1;
          strobes.clearMask  = 1'b1;
        end else if (byteStb) begin
          strobes.storeByte = 1'b1;
        end else if (stopStb) begin
          if (anyValid && !wpPin) begin
            nextState         = PB_WAIT;
            strobes.scanStart = 1'b1;
          end else begin
            strobes.clearMask = 1'b1;
          end
        end
      end
      PB_WAIT: begin
        if (waitCnt == CNT_LAST) nextState = PB_SCAN;
      end
      PB_SCAN: begin
        strobes.scanStep = 1'b1;
        if (scanLast) begin
          nextState         = PB_IDLE;
          strobes.clearMask = 1'b1;
        end
      end
      default: nextState = PB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= PB_IDLE;
      waitCnt <= '0;
    end else begin
      state   <= nextState;
      waitCnt <= (state == PB_WAIT) ? waitCnt + 1'b1 : '0;
    end
  end

  assign busy = (state != PB_IDLE);

endmodule

// File: rtl/pagebuf_dpath.sv
module pagebuf_dpath
  import pagebuf_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int PAGE_IDX_W = 9
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  pbStrobe_t                   strobes,
  input  logic [PAGE_IDX_W-1:0]       pageIn,
  input  logic [$clog2(PAGE_BYTES)-1:0] offIn,
  input  logic [7:0]                  byteData,
  output logic                        anyValid,
  output logic                        scanLast,
  output logic                        arrWrEn,
  output logic [PAGE_IDX_W+$clog2(PAGE_BYTES)-1:0] arrWrAddr,
  output logic [7:0]                  arrWrData
);

  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(PAGE_BYTES - 1);

  logic [PAGE_IDX_W-1:0] pageReg;
  logic [OFF_W-1:0]      wrPtr;
  logic [OFF_W-1:0]      scanPtr;
  logic [PAGE_BYTES-1:0] validMask;
  logic [7:0]            dataMem [PAGE_BYTES];

  // pointer and page registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg <= '0;
      wrPtr   <= '0;
      scanPtr <= '0;
    end else begin
      if (strobes.loadOffset) begin
        pageReg <= pageIn;
        wrPtr   <= offIn;
      end else if (strobes.storeByte) begin
        wrPtr <= wrPtr + 1'b1;
      end
      if (strobes.scanStart) scanPtr <= '0;
      else if (strobes.scanStep) scanPtr <= scanPtr + 1'b1;
    end
  end

  // one valid bit per offset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validMask <= '0;
    end else if (strobes.clearMask) begin
      validMask <= '0;
    end else if (strobes.storeByte) begin
      validMask[wrPtr] <= 1'b1;
    end
  end

  // byte storage, no reset needed
  always_ff @(posedge clk) begin
    if (strobes.storeByte) dataMem[wrPtr] <= byteData;
  end

  assign anyValid  = |validMask;
  assign scanLast  = (scanPtr == OFF_LAST);
  assign arrWrEn   = strobes.scanStep & validMask[scanPtr];
  assign arrWrAddr = {pageReg, scanPtr};
  assign arrWrData = dataMem[scanPtr];

endmodule

// File: rtl/pagebuf_commit.sv
module pagebuf_commit
  import pagebuf_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int PAGE_IDX_W = 9,
  parameter int CYCLE_CLKS = 250000
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [PAGE_IDX_W-1:0]         pageIn,
  input  logic [$clog2(PAGE_BYTES)-1:0] offIn,
  input  logic                          offLoad,
  input  logic                          byteStb,
  input  logic [7:0]                    byteData,
  input  logic                          stopStb,
  input  logic                          wpPin,
  output logic                          busy,
  output logic                          arrWrEn,
  output logic [PAGE_IDX_W+$clog2(PAGE_BYTES)-1:0] arrWrAddr,
  output logic [7:0]                    arrWrData
);

  pbStrobe_t strobes;
  logic anyValid;
  logic scanLast;

  pagebuf_ctrl #(.CYCLE_CLKS(CYCLE_CLKS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .offLoad  (offLoad),
    .byteStb  (byteStb),
    .stopStb  (stopStb),
    .wpPin    (wpPin),
    .anyValid (anyValid),
    .scanLast (scanLast),
    .strobes  (strobes),
    .busy     (busy)
  );

  pagebuf_dpath #(.PAGE_BYTES(PAGE_BYTES), .PAGE_IDX_W(PAGE_IDX_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .pageIn    (pageIn),
    .offIn     (offIn),
    .byteData  (byteData),
    .anyValid  (anyValid),
    .scanLast  (scanLast),
    .arrWrEn   (arrWrEn),
    .arrWrAddr (arrWrAddr),
    .arrWrData (arrWrData)
  );

endmodule

// File: rtl/pagebuf_commit_check.sv
module pagebuf_commit_check #(
  parameter int PAGE_BYTES = 256,
  parameter int PAGE_IDX_W = 9,
  parameter int CYCLE_CLKS = 250000
) (
  input logic clk,
  input logic rstN,
  input logic offLoad,
  input logic byteStb,
  input logic stopStb,
  input logic wpPin,
  input logic busy,
  input logic anyValid,
  input logic arrWrEn,
  input logic [PAGE_IDX_W+$clog2(PAGE_BYTES)-1:0] arrWrAddr
);

  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int TOTAL = CYCLE_CLKS + PAGE_BYTES;

  int busyRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= 0;
    else if (busy) busyRun <= busyRun + 1;
    else busyRun <= 0;
  end

  p_one_event_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({offLoad, byteStb, stopStb}));

  p_commit_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stopStb && !wpPin && anyValid) |=> busy);

  p_empty_stop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stopStb && !anyValid) |=> !busy);

  p_wp_block_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stopStb && wpPin) |=> !busy);

  p_wr_in_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> (busy && busyRun >= CYCLE_CLKS));

  p_busy_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyRun < TOTAL));

  p_page_fixed_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(arrWrAddr[PAGE_IDX_W+OFF_W-1:OFF_W]));

  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && busyRun == TOTAL - 1) |=> !busy);

endmodule

bind pagebuf_commit pagebuf_commit_check #(
  .PAGE_BYTES(PAGE_BYTES),
  .PAGE_IDX_W(PAGE_IDX_W),
  .CYCLE_CLKS(CYCLE_CLKS)
) u_check (
  .clk       (clk),
  .rstN      (rstN),
  .offLoad   (offLoad),
  .byteStb   (byteStb),
  .stopStb   (stopStb),
  .wpPin     (wpPin),
  .busy      (busy),
  .anyValid  (anyValid),
  .arrWrEn   (arrWrEn),
  .arrWrAddr (arrWrAddr)
);

// File: tb/pagebuf_commit_bench.sv
module pagebuf_commit_bench;

  localparam int PB  = 256;
  localparam int PIW = 9;
  localparam int CYC = 40;
  localparam int AW  = PIW + 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rstN;
  logic [PIW-1:0] pageIn;
  logic [7:0]     offIn;
  logic           offLoad, byteStb, stopStb, wpPin;
  logic [7:0]     byteData;
  logic           busy, arrWrEn;
  logic [AW-1:0]  arrWrAddr;
  logic [7:0]     arrWrData;

  pagebuf_commit #(.PAGE_BYTES(PB), .PAGE_IDX_W(PIW), .CYCLE_CLKS(CYC)) u_pagebuf_commit (
    .clk(clk), .rstN(rstN), .pageIn(pageIn), .offIn(offIn), .offLoad(offLoad),
    .byteStb(byteStb), .byteData(byteData), .stopStb(stopStb), .wpPin(wpPin),
    .busy(busy), .arrWrEn(arrWrEn), .arrWrAddr(arrWrAddr), .arrWrData(arrWrData)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference model of the pending page
  logic [7:0] expData [PB];
  bit         expMask [PB];
  int         curOff, curPage;

  // monitor of the array port
  bit         monOn = 1'b0;
  int         busyCnt, wrCnt, orderErr, pageErr, earlyErr, lastOff, mOff;
  logic [7:0] obsData [PB];
  bit         obsMask [PB];

  always @(negedge clk) begin
    if (monOn) begin
      if (busy) busyCnt++;
      if (arrWrEn) begin
        wrCnt++;
        mOff = int'(arrWrAddr[7:0]);
        if (int'(arrWrAddr[AW-1:8]) != curPage) pageErr++;
        if (mOff <= lastOff) orderErr++;
        if (busyCnt <= CYC) earlyErr++;
        lastOff = mOff;
        obsData[mOff] = arrWrData;
        obsMask[mOff] = 1'b1;
      end
    end
  end

  task automatic drive(input bit ld, input bit bs, input bit sp, input logic [7:0] d);
    @(posedge clk); #5;
    offLoad = ld; byteStb = bs; stopStb = sp; byteData = d;
  endtask

  task automatic startTxn(input int page, input int off);
    @(posedge clk); #5;
    pageIn = PIW'(page); offIn = 8'(off);
    offLoad = 1'b1; byteStb = 1'b0; stopStb = 1'b0;
    for (int i = 0; i < PB; i++) expMask[i] = 1'b0;
    curOff = off; curPage = page;
  endtask

  task automatic sendByte(input logic [7:0] v);
    drive(1'b0, 1'b1, 1'b0, v);
    expData[curOff] = v;
    expMask[curOff] = 1'b1;
    curOff = (curOff + 1) % PB;
  endtask

  task automatic sendBytes(input int n, input int seed);
    for (int i = 0; i < n; i++) sendByte(8'((seed + i * 7) & 8'hFF));
  endtask

  // Stop plus the full observation of what follows
  task automatic commitAndCheck(input bit expectBusy, input bit disturb, input string req);
    int expCnt, dataErr, waitN;
    drive(1'b0, 1'b0, 1'b0, 8'h00);
    busyCnt = 0; wrCnt = 0; orderErr = 0; pageErr = 0; earlyErr = 0; lastOff = -1;
    for (int i = 0; i < PB; i++) obsMask[i] = 1'b0;
    monOn = 1'b1;
    drive(1'b0, 1'b0, 1'b1, 8'h00);
    drive(1'b0, 1'b0, 1'b0, 8'h00);
    @(negedge clk); #1;
    check(busy == expectBusy, req, "busy after stop", int'(busy), int'(expectBusy));
    if (disturb) begin
      // R7: traffic while busy must be dropped
      @(posedge clk); #5; pageIn = 9'h0AA; offIn = 8'd0;
      offLoad = 1'b1; byteStb = 1'b0; stopStb = 1'b0;
      for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, 1'b0, 8'hEE);
      drive(1'b0, 1'b0, 1'b1, 8'h00);
      drive(1'b0, 1'b0, 1'b0, 8'h00);
    end
    waitN = 0;
    while (busy && waitN < CYC + PB + 50) begin
      @(negedge clk); #1; waitN++;
    end
    repeat (30) @(negedge clk);
    #1 monOn = 1'b0;
    expCnt = 0; dataErr = 0;
    for (int i = 0; i < PB; i++) begin
      if (!expectBusy) expMask[i] = 1'b0;
      if (expMask[i]) expCnt++;
      if (expMask[i] != obsMask[i]) dataErr++;
      else if (expMask[i] && obsData[i] != expData[i]) dataErr++;
    end
    check(busyCnt == (expectBusy ? CYC + PB : 0), req, "busy cycles (R5)",
          busyCnt, expectBusy ? CYC + PB : 0);
    check(wrCnt == expCnt, req, "write count (R8)", wrCnt, expCnt);
    check(dataErr == 0, req, "offset/data mismatches (R3)", dataErr, 0);
    check(orderErr == 0 && earlyErr == 0, req, "order/early writes (R5)",
          orderErr + earlyErr, 0);
    check(pageErr == 0, req, "page bits (R2)", pageErr, 0);
  endtask

  initial begin
    rstN = 1'b0; pageIn = '0; offIn = '0; offLoad = 1'b0; byteStb = 1'b0;
    stopStb = 1'b0; wpPin = 1'b0; byteData = '0; curOff = 0; curPage = 0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R9", "busy in reset", int'(busy), 0);
    check(arrWrEn == 1'b0, "R9", "arrWrEn in reset", int'(arrWrEn), 0);
    #3 rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R9", "busy after reset", int'(busy), 0);

    // R4 single byte
    startTxn(3, 5); sendBytes(1, 8'h5A);
    commitAndCheck(1'b1, 1'b0, "R4");

    // R2 full page from offset 0
    startTxn(9'h1FF, 0); sendBytes(PB, 3);
    commitAndCheck(1'b1, 1'b0, "R2");

    // R2 wrap from 250
    startTxn(1, 250); sendBytes(10, 100);
    commitAndCheck(1'b1, 1'b0, "R2");

    // R3 overflow by 44 bytes
    startTxn(2, 10); sendBytes(300, 17);
    commitAndCheck(1'b1, 1'b0, "R3");

    // R1 reload discards the earlier bytes
    startTxn(4, 20); sendBytes(5, 1);
    startTxn(5, 100); sendBytes(3, 200);
    commitAndCheck(1'b1, 1'b0, "R1");

    // R6 write protect at stop
    startTxn(6, 0); sendBytes(4, 50);
    drive(1'b0, 1'b0, 1'b0, 8'h00); wpPin = 1'b1;
    commitAndCheck(1'b0, 1'b0, "R6");
    wpPin = 1'b0;
    // R6 discarded bytes do not reappear
    startTxn(6, 9); sendBytes(1, 77);
    commitAndCheck(1'b1, 1'b0, "R6");

    // R4 stop with no data
    startTxn(7, 3);
    commitAndCheck(1'b0, 1'b0, "R4");

    // R6 WP high only while bytes arrive
    wpPin = 1'b1;
    startTxn(8, 128); sendBytes(6, 9);
    drive(1'b0, 1'b0, 1'b0, 8'h00); wpPin = 1'b0;
    commitAndCheck(1'b1, 1'b0, "R6");

    // R7 traffic during busy ignored
    startTxn(10, 60); sendBytes(4, 30);
    commitAndCheck(1'b1, 1'b1, "R7");
    // R8 next transaction writes only its own byte
    startTxn(11, 0); sendBytes(1, 4);
    commitAndCheck(1'b1, 1'b0, "R8");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule